// File: doc/BRIEF.md
# Protected Program Memory Port

This block is the 1 KB code-space access unit of a small 8-bit controller. It answers three kinds of request: instruction fetches, interrupt vector lookups and data reads made by the load-constant instructions. A vector lookup returns a 16-bit handler address. Fetches and data reads return a single byte. Every answer appears on a registered output one cycle after the request, with a valid strobe and an access-violation flag.

The low twelve bytes of code space form a table of six 16-bit vectors. Ordinary code starts at byte 12, and the block's own sequential fetch counter points there after reset. A protection input, when high, stops load-constant reads from returning ROM bytes. Fetches and vector lookups still work while it is high, so the code keeps running but its bytes cannot be copied out through the data path.

Top module: `prog_mem_port`

## Requirements
- R1: The code space is 1024 bytes with 10-bit addresses, and the byte held at address a is (37*a + 11) mod 256. A granted fetch returns that byte in out_data[7:0], with out_data[15:8] = 0, out_valid = 1 and out_viol = 0, one cycle after the request.
- R2: While reset is held, and in the first cycle after it, out_valid, out_viol and out_data are all 0. The first sequential fetch (fetch_jump = 0) after reset reads address 12. Each later sequential fetch reads the address one above the previous fetch, and the address wraps from 1023 to 0.
- R3: A fetch with fetch_jump = 1 reads fetch_addr. The next sequential fetch reads fetch_addr + 1.
- R4: A vector request with irq_num n in the range 0 to 5 returns {byte[2n], byte[2n+1]} one cycle later, so the even address supplies the upper byte. out_viol is 0.
- R5: A vector request with irq_num above 5 returns out_data = 0 with out_valid = 1 and out_viol = 1.
- R6: A load-constant read (ldc_req) with protect = 0 returns the byte at ldc_addr in out_data[7:0], with out_viol = 0.
- R7: A load-constant read with protect = 1 returns out_data = 0 with out_valid = 1. out_viol is high for exactly that one result cycle.
- R8: protect has no effect on fetch results, on vector results or on the sequential fetch address.
- R9: When requests arrive together, a vector request is served first, a fetch second and a load-constant read last. A request that loses is dropped, and a fetch that loses does not advance the sequential fetch address.
- R10: In a cycle after a cycle with no request, out_valid, out_viol and out_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| protect | input | 1 | Blocks load-constant reads when high |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_jump | input | 1 | Use fetch_addr instead of the sequential address |
| fetch_addr | input | 10 | Explicit fetch address |
| vec_req | input | 1 | Interrupt vector lookup request |
| irq_num | input | 3 | Interrupt number for the lookup |
| ldc_req | input | 1 | Load-constant data read request |
| ldc_addr | input | 10 | Load-constant read address |
| out_data | output | 16 | Returned byte (zero-extended) or vector |
| out_valid | output | 1 | Result present this cycle |
| out_viol | output | 1 | Access violation for this result |

## Verification
A sequential fetch counter that is wrong shows up at the very next sequential fetch as the wrong ROM byte. From then on every sequential result is off by the same amount until a jump reloads the counter, so one sequential fetch after reset, after a jump or after a lost arbitration shows the fault. A protection or arbitration fault shows up one cycle after the request that triggers it, as a ROM byte where zero was due, a missing violation flag or a result from the wrong requester. The bench compares every output on every cycle against a behavioural model, so each of these shows up in the cycle it occurs.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_VEC   = 2'd1,
    SRC_FETCH = 2'd2,
    SRC_LDC   = 2'd3
  } pmem_src_e;

  // Fixed contents of the code space: an affine pattern over the byte address.
  function automatic logic [7:0] rom_pattern(input int unsigned a);
    int unsigned v;
    v = a * 37 + 11;
    return v[7:0];
  endfunction

endpackage

// File: rtl/pmem_rom.sv
module pmem_rom #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [7:0]        data_a,
  output logic [7:0]        data_b
);
  import pmem_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_pattern(i);
  end

  assign data_a = mem[addr_a];
  assign data_b = mem[addr_b];

endmodule

// File: rtl/pmem_fetch_ctr.sv
module pmem_fetch_ctr #(
  parameter int ADDR_W    = 10,
  parameter int BOOT_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] BOOT = ADDR_W'(BOOT_ADDR);

  logic [ADDR_W-1:0] pc;
  logic              booted;   // set once the first fetch has been served

  assign cur_addr = jump ? jump_addr : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= BOOT;
      booted <= 1'b0;
    end else if (grant) begin
      pc     <= cur_addr + 1'b1;
      booted <= 1'b1;
    end
  end

  assert_boot_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !jump && !booted) |-> (cur_addr == BOOT));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant) |=> (pc == $past(pc)));

endmodule

// File: rtl/pmem_arbiter.sv
module pmem_arbiter #(
  parameter int ADDR_W  = 10,
  parameter int NUM_VEC = 6,
  parameter int IRQ_W   = 3
) (
  input  logic                vec_req,
  input  logic [IRQ_W-1:0]    irq_num,
  input  logic                fetch_req,
  input  logic [ADDR_W-1:0]   fetch_cur,
  input  logic                ldc_req,
  input  logic [ADDR_W-1:0]   ldc_addr,
  input  logic                protect,
  output pmem_pkg::pmem_src_e src,
  output logic                fetch_grant,
  output logic                vec_bad,
  output logic                ldc_blocked,
  output logic [ADDR_W-1:0]   addr_a,
  output logic [ADDR_W-1:0]   addr_b
);
  import pmem_pkg::*;

  function automatic logic [ADDR_W-1:0] vec_hi_addr(input logic [IRQ_W-1:0] n);
    return ADDR_W'(n) << 1;
  endfunction

  always_comb begin
    if (vec_req)        src = SRC_VEC;
    else if (fetch_req) src = SRC_FETCH;
    else if (ldc_req)   src = SRC_LDC;
    else                src = SRC_NONE;
  end

  assign fetch_grant = (src == SRC_FETCH);
  assign vec_bad     = (src == SRC_VEC) && (int'(irq_num) >= NUM_VEC);
  assign ldc_blocked = (src == SRC_LDC) && protect;

  always_comb begin
    addr_a = '0;
    addr_b = '0;
    unique case (src)
      SRC_VEC: begin
        addr_a = vec_hi_addr(irq_num);
        addr_b = vec_hi_addr(irq_num) + 1'b1;
      end
      SRC_FETCH: addr_a = fetch_cur;
      SRC_LDC:   addr_a = ldc_addr;
      default: ;
    endcase
  end

endmodule

// File: rtl/prog_mem_port.sv
module prog_mem_port #(
  parameter int ADDR_W    = 10,
  parameter int NUM_VEC   = 6,
  parameter int IRQ_W     = 3,
  parameter int BOOT_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              protect,
  input  logic              fetch_req,
  input  logic              fetch_jump,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              vec_req,
  input  logic [IRQ_W-1:0]  irq_num,
  input  logic              ldc_req,
  input  logic [ADDR_W-1:0] ldc_addr,
  output logic [15:0]       out_data,
  output logic              out_valid,
  output logic              out_viol
);
  import pmem_pkg::*;

  pmem_src_e         src;
  logic              fetch_grant, vec_bad, ldc_blocked;
  logic [ADDR_W-1:0] fetch_cur, addr_a, addr_b;
  logic [7:0]        byte_a, byte_b;
  logic              any_req;

  assign any_req = vec_req | fetch_req | ldc_req;

  pmem_fetch_ctr #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_ctr (
    .clk(clk), .rst_n(rst_n), .grant(fetch_grant), .jump(fetch_jump),
    .jump_addr(fetch_addr), .cur_addr(fetch_cur)
  );

  pmem_arbiter #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .IRQ_W(IRQ_W)) u_arb (
    .vec_req(vec_req), .irq_num(irq_num), .fetch_req(fetch_req),
    .fetch_cur(fetch_cur), .ldc_req(ldc_req), .ldc_addr(ldc_addr),
    .protect(protect), .src(src), .fetch_grant(fetch_grant),
    .vec_bad(vec_bad), .ldc_blocked(ldc_blocked),
    .addr_a(addr_a), .addr_b(addr_b)
  );

  pmem_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr_a(addr_a), .addr_b(addr_b), .data_a(byte_a), .data_b(byte_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_viol  <= 1'b0;
    end else begin
      out_valid <= (src != SRC_NONE);
      out_viol  <= vec_bad | ldc_blocked;
      unique case (src)
        SRC_VEC:   out_data <= vec_bad ? 16'h0000 : {byte_a, byte_b};
        SRC_FETCH: out_data <= {8'h00, byte_a};
        SRC_LDC:   out_data <= ldc_blocked ? 16'h0000 : {8'h00, byte_a};
        default:   out_data <= 16'h0000;
      endcase
    end
  end

  assert_viol_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_viol |-> out_valid);

  assert_blocked_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ldc_blocked |=> (out_viol && out_data == 16'h0000));

  assert_bad_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && int'(irq_num) >= NUM_VEC) |=> (out_viol && out_data == 16'h0000));

  assert_fetch_unblocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !vec_req) |=> (out_valid && !out_viol && out_data[15:8] == 8'h00));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req) |=> (!out_valid && !out_viol && out_data == 16'h0000));

  assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> out_valid);

endmodule

// File: tb/sim_prog_mem_port.sv
`timescale 1ns/100ps
module sim_prog_mem_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        protect = 1'b0;
  logic        fetch_req = 1'b0, fetch_jump = 1'b0;
  logic [9:0]  fetch_addr = '0;
  logic        vec_req = 1'b0;
  logic [2:0]  irq_num = '0;
  logic        ldc_req = 1'b0;
  logic [9:0]  ldc_addr = '0;
  logic [15:0] out_data;
  logic        out_valid, out_viol;

  always #2.5 clk = ~clk;

  prog_mem_port u0 (
    .clk(clk), .rst_n(rst_n), .protect(protect),
    .fetch_req(fetch_req), .fetch_jump(fetch_jump), .fetch_addr(fetch_addr),
    .vec_req(vec_req), .irq_num(irq_num), .ldc_req(ldc_req), .ldc_addr(ldc_addr),
    .out_data(out_data), .out_valid(out_valid), .out_viol(out_viol)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int          m_pc;
  logic [15:0] e_data;
  logic        e_valid, e_viol;
  string       e_tag;

  function automatic int code_byte(int a);
    return ((37 * a) + 11) % 256;
  endfunction

  task automatic check(string tag, logic [15:0] d, logic v, logic x,
                       logic [15:0] ed, logic ev, logic ex);
    checks++;
    if (d !== ed || v !== ev || x !== ex) begin
      fails++;
      $display("FAIL %s: data=%h valid=%b viol=%b, expected data=%h valid=%b viol=%b",
               tag, d, v, x, ed, ev, ex);
    end
  endtask

  // Apply one cycle of stimulus (called at a negedge), predict the result,
  // then compare at the following negedge.
  task automatic cyc(bit f, bit j, int fa, bit vr, int n, bit lr, int la, bit p);
    fetch_req = f; fetch_jump = j; fetch_addr = 10'(fa);
    vec_req = vr; irq_num = 3'(n); ldc_req = lr; ldc_addr = 10'(la); protect = p;
    if (vr) begin
      e_valid = 1;
      if (n > 5) begin e_data = 0; e_viol = 1; e_tag = "R5 vector out of range"; end
      else begin
        e_data = 16'((code_byte(2*n) * 256) + code_byte(2*n + 1));
        e_viol = 0;
        e_tag = (f || lr) ? "R9 vector wins" : (p ? "R8 vector under protect" : "R4 vector lookup");
      end
    end else if (f) begin
      int a;
      a = j ? fa : m_pc;
      m_pc = (a + 1) % 1024;
      e_valid = 1; e_viol = 0; e_data = 16'(code_byte(a));
      e_tag = lr ? "R9 fetch beats ldc" : (p ? "R8 fetch under protect" :
              (j ? "R3 jump fetch" : "R2 sequential fetch"));
    end else if (lr) begin
      e_valid = 1;
      if (p) begin e_data = 0; e_viol = 1; e_tag = "R7 blocked ldc"; end
      else begin e_data = 16'(code_byte(la)); e_viol = 0; e_tag = "R6 open ldc"; end
    end else begin
      e_valid = 0; e_viol = 0; e_data = 0; e_tag = "R10 idle";
    end
    @(negedge clk);
    check(e_tag, out_data, out_valid, out_viol, e_data, e_valid, e_viol);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_pc = 12;
    repeat (3) @(negedge clk);
    check("R2 reset state", out_data, out_valid, out_viol, 16'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", out_data, out_valid, out_viol, 16'h0, 1'b0, 1'b0);
    // R2 sequential from boot address
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    // R3 jump, then sequential; R1 top of space and wrap
    cyc(1, 1, 1023, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 500, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    // R4 / R5 all vector numbers
    for (int n = 0; n < 8; n++) cyc(0, 0, 0, 1, n, 0, 0, 0);
    // R6 / R7 load-constant, including vector area and top
    cyc(0, 0, 0, 0, 0, 1, 3, 0);
    cyc(0, 0, 0, 0, 0, 1, 1023, 0);
    cyc(0, 0, 0, 0, 0, 1, 3, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);      // R7 violation lasts one cycle
    cyc(0, 0, 0, 0, 0, 1, 700, 1);
    // R8 protect does not disturb fetch or vectors
    cyc(1, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 2, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, 1);
    // R9 priority and dropped requests
    cyc(1, 0, 0, 1, 5, 1, 9, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);      // pc must not have moved
    cyc(0, 0, 0, 1, 1, 1, 9, 1);
    cyc(1, 1, 40, 0, 0, 1, 9, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);      // R10
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 55, $urandom_range(0, 3) == 0, $urandom_range(0, 1023),
          r > 85, $urandom_range(0, 7),
          (r > 40) && (r < 95), $urandom_range(0, 1023), $urandom_range(0, 1) == 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule